// File: doc/BRIEF.md
# Paired-Output FIR Convolution Datapath

This block is the arithmetic core of a FIR filter. It produces two adjacent output samples, y[n] and y[n-1], in one pass over the coefficient set. The block holds four 16-bit samples in a shift line and two 16-bit coefficients in a bank. Two 32-bit accumulators are each fed by a pair of multipliers. Each load strobe accepts a 32-bit word carrying two samples. It pushes that pair into the front of the line and moves the previous front pair to the back. The coefficient word carrying two taps is captured in the same cycle.

A controller outside the block runs the filter. It first clears the accumulators to the rounding constant. It then issues two priming loads and then N/2 combined load-and-convolve cycles, each of which consumes two taps for both outputs. Finally it issues a store, which emits both rounded results packed into one 32-bit word. Address generation, memories and loop control belong to the controller, not to this block.

Top module: `fir_pair_mac`

## Requirements
- R1: While `rst_n` is low at a clock edge, every sample, coefficient and accumulator is cleared, and `out_word` and `out_valid` become 0.
- R2: A cycle with `ld` high moves the front pair of the line (slots 0 and 1) into slots 2 and 3. In the same edge it writes `smp_word[15:0]` into slot 0 (the newer sample) and `smp_word[31:16]` into slot 1. Without `ld` the line holds.
- R3: A cycle with `ld` high captures `coef_word[15:0]` as c0 and `coef_word[31:16]` as c1. The multipliers in that cycle use these incoming taps. A convolve cycle without `ld` uses the held taps.
- R4: A cycle with `conv` high (and `acc_clr` low) sets ACC0 += s2·c0 + s3·c1 and ACC1 += s3·c0 + s0·c1. All samples s0..s3 and the taps c0, c1 are signed Q15, and the samples are the line contents from before that cycle's shift.
- R5: `acc_clr` loads 0x00008000 into both accumulators and takes priority over `conv`.
- R6: One cycle after `store` is high, `out_word[15:0]` holds ACC0[31:16] and `out_word[31:16]` holds ACC1[31:16], taken from the values before that edge. `out_valid` is high in exactly the cycles that follow a `store` cycle.
- R7: The accumulators are 32-bit two's complement and wrap on overflow without saturating.
- R8: After a clear, two priming loads carrying x[n]..x[n-3] and 20 load-and-convolve cycles carrying taps h[2k], h[2k+1], a store returns the rounded 40-tap y[n] in the low half and y[n-1] in the high half.
- R9: In a cycle with both `acc_clr` and `conv` low, both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_clr | input | 1 | Load the rounding constant into both accumulators |
| ld | input | 1 | Shift a sample pair in and capture a coefficient pair |
| conv | input | 1 | Perform the four multiply-accumulates |
| store | input | 1 | Emit the packed rounded results next cycle |
| smp_word | input | 32 | Two samples: newer in the low half |
| coef_word | input | 32 | Two taps: c0 low, c1 high |
| out_word | output | 32 | ACC1 high half above ACC0 high half |
| out_valid | output | 1 | Marks a packed result |

## Verification
Loads, clears and multiply-accumulates take effect at the edge that samples the strobes. A store's packed word and its valid flag appear one register later. This means the result reflects the accumulators as they stood before that edge, even when `conv` is high in the same cycle. The bench drives every strobe half a period before an edge. It advances its own model of the line, the taps and the accumulators at that edge, and compares the outputs 5 ns after the edge against the word captured before the model's update. The 40-tap case is checked against a direct convolution sum rather than the step model.

// File: rtl/fir_pair_pkg.sv
// Shared constants for the paired-output FIR datapath.
// Assumes signed fixed-point samples and a rounding bias at half an output LSB.
package fir_pair_pkg;
    localparam int SMP_W_DEF = 16;
    localparam int ACC_W_DEF = 32;
    localparam int LINE_N    = 4;

    // Rounding constant: half of one LSB of the kept upper field.
    function automatic logic [ACC_W_DEF-1:0] rnd_bias(input int acc_w, input int smp_w);
        logic [ACC_W_DEF-1:0] v;
        v = '0;
        v[acc_w-smp_w-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/fir_tap_line.sv
// Four-slot sample shift line. A load writes a new pair into slots 0/1
// and pushes the old front pair into slots 2/3.
// Assumes the pair word carries the newer sample in its low half.
module fir_tap_line #(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [2*SMP_W-1:0]      pair_i,
    output logic signed [SMP_W-1:0] slot_o [0:3]
);
    logic signed [SMP_W-1:0] slot_q [0:3];

    for (genvar i = 0; i < 4; i++) begin : g_slot
        // Per-slot update: front slots take the new pair, back slots the old front.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (ld) begin
                if (i < 2)
                    slot_q[i] <= pair_i[i*SMP_W +: SMP_W];
                else
                    slot_q[i] <= slot_q[i-2];
            end
        end
        assign slot_o[i] = slot_q[i];
    end

    a_r2_pair_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (slot_q[2] == $past(slot_q[0])) && (slot_q[3] == $past(slot_q[1])));
    a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(slot_q[0]) && $stable(slot_q[1]) && $stable(slot_q[2]) && $stable(slot_q[3]));
endmodule

// File: rtl/fir_coef_bank.sv
// Two-entry coefficient bank. Captures a tap pair on load and forwards
// the incoming pair in that same cycle so a combined load+convolve uses fresh taps.
module fir_coef_bank #(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [2*SMP_W-1:0]      pair_i,
    output logic signed [SMP_W-1:0] c0_o,
    output logic signed [SMP_W-1:0] c1_o
);
    logic signed [SMP_W-1:0] c0_q, c1_q;

    // Tap capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_q <= '0;
            c1_q <= '0;
        end else if (ld) begin
            c0_q <= pair_i[SMP_W-1:0];
            c1_q <= pair_i[2*SMP_W-1:SMP_W];
        end
    end

    // Effective taps: incoming pair during a load, held pair otherwise.
    always_comb begin
        c0_o = ld ? pair_i[SMP_W-1:0]       : c0_q;
        c1_o = ld ? pair_i[2*SMP_W-1:SMP_W] : c1_q;
    end

    a_r3_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(c0_q) && $stable(c1_q));
    a_r3_taps_seen: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |-> (c0_o == c0_q) && (c1_o == c1_q));
endmodule

// File: rtl/fir_mac_lane.sv
// One accumulator fed by two signed multipliers. Clear loads the rounding
// bias and wins over accumulate; sums wrap in two's complement.
module fir_mac_lane #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    conv,
    input  logic signed [SMP_W-1:0] a0_i,
    input  logic signed [SMP_W-1:0] b0_i,
    input  logic signed [SMP_W-1:0] a1_i,
    input  logic signed [SMP_W-1:0] b1_i,
    output logic [SMP_W-1:0]        res_o
);
    localparam logic [ACC_W-1:0] BIAS = ACC_W'(fir_pair_pkg::rnd_bias(ACC_W, SMP_W));

    logic signed [2*SMP_W-1:0] prod0, prod1;
    logic signed [ACC_W-1:0]   acc_q, acc_sum;

    // Two products and their wrapped sum with the accumulator.
    always_comb begin
        prod0   = a0_i * b0_i;
        prod1   = a1_i * b1_i;
        acc_sum = acc_q + ACC_W'(prod0) + ACC_W'(prod1);
    end

    // Accumulator register: clear first, then accumulate, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr)
            acc_q <= BIAS;
        else if (conv)
            acc_q <= acc_sum;
    end

    assign res_o = acc_q[ACC_W-1 -: SMP_W];

    a_r5_clear_bias: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_q == BIAS);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !conv) |=> $stable(acc_q));
endmodule

// File: rtl/fir_pair_mac.sv
// Paired-output FIR datapath top: shift line, tap bank, two MAC lanes and
// a registered packed result. Lane 0 builds y[n], lane 1 builds y[n-1].
module fir_pair_mac #(
    parameter int SMP_W = fir_pair_pkg::SMP_W_DEF,
    parameter int ACC_W = fir_pair_pkg::ACC_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_clr,
    input  logic               ld,
    input  logic               conv,
    input  logic               store,
    input  logic [2*SMP_W-1:0] smp_word,
    input  logic [2*SMP_W-1:0] coef_word,
    output logic [2*SMP_W-1:0] out_word,
    output logic               out_valid
);
    localparam int LANES = 2;

    logic signed [SMP_W-1:0] slot [0:fir_pair_pkg::LINE_N-1];
    logic signed [SMP_W-1:0] c0, c1;
    logic [SMP_W-1:0]        res [0:LANES-1];
    logic [2*SMP_W-1:0]      packed_res;

    fir_tap_line #(.SMP_W(SMP_W)) i_line (
        .clk(clk), .rst_n(rst_n), .ld(ld), .pair_i(smp_word), .slot_o(slot));

    fir_coef_bank #(.SMP_W(SMP_W)) i_taps (
        .clk(clk), .rst_n(rst_n), .ld(ld), .pair_i(coef_word), .c0_o(c0), .c1_o(c1));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane 0 pairs slots 2/3, lane 1 pairs slots 3/0 with c0/c1.
        localparam int IA = (l == 0) ? 2 : 3;
        localparam int IB = (l == 0) ? 3 : 0;
        fir_mac_lane #(.SMP_W(SMP_W), .ACC_W(ACC_W)) i_lane (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .conv(conv),
            .a0_i(slot[IA]), .b0_i(c0), .a1_i(slot[IB]), .b1_i(c1),
            .res_o(res[l]));
        assign packed_res[l*SMP_W +: SMP_W] = res[l];
    end

    // Output register: capture packed rounded results on store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= store;
            if (store)
                out_word <= packed_res;
        end
    end

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> out_valid);
    a_r6_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> !out_valid);
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> $stable(out_word));
endmodule

// File: tb/test_fir_pair_mac.sv
`timescale 1ns/1ps
module test_fir_pair_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_clr = 1'b0, ld = 1'b0, conv = 1'b0, store = 1'b0;
    logic [31:0] smp_word = '0, coef_word = '0;
    logic [31:0] out_word;
    logic        out_valid;

    int n_run = 0;
    int n_fail = 0;

    // Bench model state
    logic signed [15:0] m_slot [0:3];
    logic signed [15:0] m_c0, m_c1;
    logic [31:0]        m_acc0, m_acc1;

    always #10 clk = ~clk;

    fir_pair_mac i_fir_pair_mac (
        .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .ld(ld), .conv(conv),
        .store(store), .smp_word(smp_word), .coef_word(coef_word),
        .out_word(out_word), .out_valid(out_valid));

    function automatic logic [31:0] mac2(input logic [31:0] acc,
        input logic signed [15:0] a0, input logic signed [15:0] b0,
        input logic signed [15:0] a1, input logic signed [15:0] b1);
        longint s;
        s = longint'(signed'(acc)) + longint'(a0) * longint'(b0) + longint'(a1) * longint'(b1);
        return s[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, check 5 ns later.
    task automatic cyc(input bit c, input bit l, input bit v, input bit s,
                       input logic [31:0] sw, input logic [31:0] cw, input string tag);
        logic [31:0] pre;
        logic signed [15:0] e0, e1;
        @(negedge clk);
        acc_clr = c; ld = l; conv = v; store = s; smp_word = sw; coef_word = cw;
        @(posedge clk);
        pre = {m_acc1[31:16], m_acc0[31:16]};
        e0 = l ? cw[15:0]  : m_c0;
        e1 = l ? cw[31:16] : m_c1;
        if (c) begin
            m_acc0 = 32'h0000_8000; m_acc1 = 32'h0000_8000;
        end else if (v) begin
            m_acc0 = mac2(m_acc0, m_slot[2], e0, m_slot[3], e1);
            m_acc1 = mac2(m_acc1, m_slot[3], e0, m_slot[0], e1);
        end
        if (l) begin
            m_slot[2] = m_slot[0]; m_slot[3] = m_slot[1];
            m_slot[0] = sw[15:0];  m_slot[1] = sw[31:16];
            m_c0 = cw[15:0]; m_c1 = cw[31:16];
        end
        #5;
        if (s) begin
            check({tag, " R6 packed word"}, out_word, pre);
            check("R6 valid after store", {31'd0, out_valid}, 32'd1);
        end else if (out_valid !== 1'b0) begin
            check("R6 valid without store", {31'd0, out_valid}, 32'd0);
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, '0, '0, "idle");
    endtask

    initial begin
        #(64'd4_000_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic signed [15:0] xs [0:43];
        logic signed [15:0] hs [0:39];
        longint y0, y1;
        logic [31:0] t0, t1;
        void'($urandom(32'd1357));
        for (int i = 0; i < 4; i++) m_slot[i] = '0;
        m_c0 = '0; m_c1 = '0; m_acc0 = '0; m_acc1 = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 out_word after reset", out_word, 32'd0);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        cyc(0, 0, 0, 0, '0, '0, "R1");
        cyc(0, 0, 0, 1, '0, '0, "R1 cleared accumulators");

        // R2/R4: directed line shift, observed through a convolve with unit-half taps
        cyc(1, 0, 0, 0, '0, '0, "R5");
        cyc(0, 1, 0, 0, 32'h2222_1111, 32'h0000_4000, "R2");
        cyc(0, 1, 0, 0, 32'h4444_3333, 32'h0000_4000, "R2");
        cyc(0, 0, 1, 0, '0, '0, "R4");
        cyc(0, 0, 0, 1, '0, '0, "R2 R4 slot order");
        idle();

        // R5: clear beats convolve; R9: idle holds
        cyc(1, 0, 1, 0, '0, '0, "R5");
        cyc(0, 0, 0, 1, '0, '0, "R5 clear over conv");
        cyc(0, 0, 1, 0, '0, '0, "R4");
        idle(); idle();
        cyc(0, 0, 0, 1, '0, '0, "R9 hold");
        cyc(0, 0, 0, 1, '0, '0, "R9 hold again");

        // R3: convolve with held taps; R7: wrap on overflow
        cyc(1, 1, 0, 0, 32'h7fff_7fff, 32'h7fff_7fff, "R3");
        cyc(0, 1, 0, 0, 32'h7fff_7fff, 32'h7fff_7fff, "R3");
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 1, 0, '0, '0, "R7");
            cyc(0, 0, 0, 1, '0, '0, "R3 R7 wrap");
        end
        cyc(1, 1, 0, 0, 32'h8000_8000, 32'h8000_7fff, "R7");
        cyc(0, 1, 0, 0, 32'h8000_8000, 32'h8000_8000, "R7");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0, '0, '0, "R7");
        cyc(0, 0, 0, 1, '0, '0, "R7 negative wrap");

        // R8: full 40-tap run checked against direct convolution
        for (int rep = 0; rep < 3; rep++) begin
            for (int i = 0; i < 44; i++) xs[i] = 16'($urandom);
            for (int i = 0; i < 40; i++) hs[i] = 16'($urandom);
            if (rep == 2) begin
                for (int i = 0; i < 44; i++) xs[i] = 16'sh8000;
                for (int i = 0; i < 40; i++) hs[i] = 16'sh8000;
            end
            cyc(1, 0, 0, 0, '0, '0, "R8");
            cyc(0, 1, 0, 0, {xs[1], xs[0]}, '0, "R8");
            cyc(0, 1, 0, 0, {xs[3], xs[2]}, '0, "R8");
            for (int k = 0; k < 20; k++)
                cyc(0, 1, 1, 0, {xs[2*k+5], xs[2*k+4]}, {hs[2*k+1], hs[2*k]}, "R8");
            cyc(0, 0, 0, 1, '0, '0, "R8 model");
            y0 = 64'sh8000; y1 = 64'sh8000;
            for (int i = 0; i < 40; i++) begin
                y0 += longint'(xs[i]) * longint'(hs[i]);
                y1 += longint'(xs[i+1]) * longint'(hs[i]);
            end
            t0 = y0[31:0]; t1 = y1[31:0];
            check("R8 y[n] and y[n-1] rounded", out_word, {t1[31:16], t0[31:16]});
        end

        // Random mix over all strobes
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 6, $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
                $urandom_range(0, 3) == 0, $urandom, $urandom, "R2 R3 R4 random");
        end
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule